// File: doc/BRIEF.md
# Fast Ethernet receive symbol decoder

This block sits behind the clock-recovery stage of a 100 Mb/s twisted-pair or fiber receiver. It takes one line symbol per cycle of the 125 MHz recovered clock. It turns the symbols back into NRZ bits and removes the scrambling. It then finds the start of each frame, converts the 5-bit code groups into nibbles and presents them as MII-style receive data with a per-nibble strobe.

In copper mode each symbol is a three-level MLT3 sample. The descrambler locks by seeding itself from the all-ones idle stream and then confirming a run of clean idles. In fiber mode each symbol is a plain NRZI bit, and both the MLT3 stage and the descrambler are skipped. Frame alignment comes from the start-of-stream pair J K. A frame ends on the T R end pair, or early when idle comes back. Code groups that are not defined raise an error flag on their nibble. If no idle is seen for too long, the block drops lock and searches again.

Top module: `fe_rx_symdec`

## Requirements
- R1: In copper mode `line_lvl` is an MLT3 level: 2'b00 is zero, 2'b01 is positive and 2'b10 is negative. Any non-zero level is NRZI 1, and a zero level is NRZI 0.
- R2: An NRZI level that differs from the previous cycle's level yields NRZ 1. An unchanged level yields NRZ 0.
- R3: The copper descrambler XORs each bit with key k = s[10] ^ s[8], then shifts k into an 11-bit register. While acquiring, it shifts in the inverted received bits for 11 cycles. `scr_locked` rises after LOCK_RUN further descrambled ones in a row.
- R4: When the last 10 descrambled bits equal 11000 10001 (J then K, oldest bit first), the bits that follow are grouped in fives. `rx_dv` first goes high together with the `rx_stb` of the first data nibble.
- R5: A group is formed with its first-received bit as the MSB and decoded as follows: 0:11110 1:01001 2:10100 3:10101 4:01010 5:01011 6:01110 7:01111 8:10010 9:10011 A:10110 B:10111 C:11010 D:11011 E:11100 F:11101. `rx_stb` pulses for one cycle with each nibble, and two strobes are never adjacent.
- R6: The group 01101 (T) inside a frame drops `rx_dv`. Neither T nor the following group (R, 00111) produces a strobe.
- R7: The group 11111 (idle) inside a frame drops `rx_dv` and ends the frame without a strobe.
- R8: Any other group inside a frame gives a strobe with `rx_dv`=1, `rx_er`=1 and `rxd`=0. `rx_er` is never high while `rx_dv` is low.
- R9: While locked in copper mode, lock is dropped after TIMEOUT cycles without a run of IDLE_SEEN descrambled ones. A frame in progress then ends, and `rx_dv` is low the cycle after `scr_locked` is low.
- R10: In fiber mode `line_lvl[0]` is the NRZI bit and no descrambling is applied. `scr_locked` reads 1, and frames decode as in R4 to R8.
- R11: After reset `rx_dv`, `rx_er`, `rx_stb` and `scr_locked` (copper mode) are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz recovered symbol clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fiber_mode | input | 1 | 1 selects fiber NRZI input and bypasses MLT3 decoding and descrambling |
| line_lvl | input | 2 | Line symbol: MLT3 level in copper mode, NRZI bit in bit 0 in fiber mode |
| rxd | output | 4 | Decoded receive nibble |
| rx_dv | output | 1 | High while a frame is being delivered |
| rx_er | output | 1 | Marks the current nibble as coming from an undefined group |
| rx_stb | output | 1 | One-cycle pulse for each new nibble |
| scr_locked | output | 1 | Descrambler locked (always 1 in fiber mode) |

## Verification
The lock timeout and the decoding of a data group can fall in the same cycle. This happens when a frame runs longer than the timeout, because no data sequence holds enough consecutive ones to count as idle. The bench provokes this with a copper frame of several hundred nibbles. It requires that the strobed nibbles form an exact prefix of the sent payload, ending well before the payload does. It also requires that `scr_locked` and `rx_dv` are low before the end delimiter, and that the block relocks on the idles that follow.

// File: rtl/fe_rx_symdec.sv
module fe_rx_symdec #(
  parameter int LOCK_RUN  = 24,
  parameter int IDLE_SEEN = 10,
  parameter int TIMEOUT   = 2000
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fiber_mode,
  input  logic [1:0] line_lvl,
  output logic [3:0] rxd,
  output logic       rx_dv,
  output logic       rx_er,
  output logic       rx_stb,
  output logic       scr_locked
);

  localparam int RW = $clog2(LOCK_RUN + 1);
  localparam int IW = $clog2(IDLE_SEEN + 1);
  localparam int TW = $clog2(TIMEOUT + 1);
  localparam logic [9:0] PAT_JK = 10'b11000_10001;
  localparam logic [4:0] GRP_T  = 5'b01101;
  localparam logic [4:0] GRP_I  = 5'b11111;

  typedef enum logic [1:0] {S_ACQ, S_CHK, S_LOCK} sst_t;
  typedef enum logic [1:0] {F_IDLE, F_DATA, F_END} fst_t;

  sst_t          sst;
  fst_t          fst;
  logic          prev_nrzi;
  logic [10:0]   sr;
  logic [3:0]    ld_cnt;
  logic [RW-1:0] run_cnt;
  logic [IW-1:0] ones_cnt;
  logic [TW-1:0] tmo_cnt;
  logic [9:0]    win;
  logic [2:0]    bcnt;

  logic       nrzi, nrz, key, dbit, lk;
  logic [9:0] wn;
  logic [4:0] grp, dec;

  assign nrzi       = fiber_mode ? line_lvl[0] : |line_lvl;
  assign nrz        = nrzi ^ prev_nrzi;
  assign key        = sr[10] ^ sr[8];
  assign dbit       = fiber_mode ? nrz : (nrz ^ key);
  assign lk         = fiber_mode | (sst == S_LOCK);
  assign scr_locked = lk;
  assign wn         = {win[8:0], dbit};
  assign grp        = wn[4:0];

  function automatic logic [4:0] dec5(input logic [4:0] g);
    case (g)
      5'b11110: return 5'h10;
      5'b01001: return 5'h11;
      5'b10100: return 5'h12;
      5'b10101: return 5'h13;
      5'b01010: return 5'h14;
      5'b01011: return 5'h15;
      5'b01110: return 5'h16;
      5'b01111: return 5'h17;
      5'b10010: return 5'h18;
      5'b10011: return 5'h19;
      5'b10110: return 5'h1A;
      5'b10111: return 5'h1B;
      5'b11010: return 5'h1C;
      5'b11011: return 5'h1D;
      5'b11100: return 5'h1E;
      5'b11101: return 5'h1F;
      default:  return 5'h00;
    endcase
  endfunction

  assign dec = dec5(grp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_nrzi <= 1'b0;
      sr        <= '0;
      sst       <= S_ACQ;
      ld_cnt    <= '0;
      run_cnt   <= '0;
      ones_cnt  <= '0;
      tmo_cnt   <= '0;
    end else begin
      prev_nrzi <= nrzi;
      sr        <= (sst == S_ACQ) ? {sr[9:0], ~nrz} : {sr[9:0], key};
      if (!dbit)
        ones_cnt <= '0;
      else if (ones_cnt != IW'(IDLE_SEEN))
        ones_cnt <= ones_cnt + 1'b1;
      case (sst)
        S_ACQ: begin
          if (ld_cnt == 4'd10) begin
            sst     <= S_CHK;
            ld_cnt  <= '0;
            run_cnt <= '0;
          end else begin
            ld_cnt <= ld_cnt + 1'b1;
          end
        end
        S_CHK: begin
          if (!dbit) begin
            sst <= S_ACQ;
          end else if (run_cnt == RW'(LOCK_RUN - 1)) begin
            sst     <= S_LOCK;
            tmo_cnt <= '0;
          end else begin
            run_cnt <= run_cnt + 1'b1;
          end
        end
        default: begin
          if (ones_cnt == IW'(IDLE_SEEN)) begin
            tmo_cnt <= '0;
          end else if (tmo_cnt == TW'(TIMEOUT - 1)) begin
            sst     <= S_ACQ;
            tmo_cnt <= '0;
          end else begin
            tmo_cnt <= tmo_cnt + 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fst    <= F_IDLE;
      win    <= '1;
      bcnt   <= '0;
      rxd    <= '0;
      rx_dv  <= 1'b0;
      rx_er  <= 1'b0;
      rx_stb <= 1'b0;
    end else begin
      win    <= wn;
      rx_stb <= 1'b0;
      if (!lk) begin
        fst   <= F_IDLE;
        rx_dv <= 1'b0;
        rx_er <= 1'b0;
      end else begin
        case (fst)
          F_IDLE: begin
            if (wn == PAT_JK) begin
              fst  <= F_DATA;
              bcnt <= '0;
            end
          end
          F_DATA: begin
            if (bcnt == 3'd4) begin
              bcnt <= '0;
              if (grp == GRP_T) begin
                fst   <= F_END;
                rx_dv <= 1'b0;
                rx_er <= 1'b0;
              end else if (grp == GRP_I) begin
                fst   <= F_IDLE;
                rx_dv <= 1'b0;
                rx_er <= 1'b0;
              end else begin
                rx_stb <= 1'b1;
                rx_dv  <= 1'b1;
                rx_er  <= ~dec[4];
                rxd    <= dec[3:0];
              end
            end else begin
              bcnt <= bcnt + 1'b1;
            end
          end
          default: begin
            if (bcnt == 3'd4) begin
              fst  <= F_IDLE;
              bcnt <= '0;
            end else begin
              bcnt <= bcnt + 1'b1;
            end
          end
        endcase
      end
    end
  end

  assert_stb_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stb |=> !rx_stb);
  assert_stb_dv_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stb |-> rx_dv);
  assert_dv_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_dv) |-> rx_stb);
  assert_er_dv_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_er |-> rx_dv);
  assert_unlock_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !scr_locked |=> !rx_dv);

endmodule

// File: tb/fe_rx_symdec_tb_top.sv
module fe_rx_symdec_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fiber_mode = 1'b0;
  logic [1:0] line_lvl = 2'b00;
  logic [3:0] rxd;
  logic       rx_dv, rx_er, rx_stb, scr_locked;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [10:0] tx_sr = 11'h5A3;
  logic [1:0]  mlt_ph = 2'd0;
  logic        fnz = 1'b0;

  logic [3:0] cap_d [0:511];
  logic       cap_e [0:511];
  logic [3:0] exp_d [0:511];
  logic       exp_e [0:511];
  int ncap = 0;
  int nexp = 0;

  fe_rx_symdec dut_i (
    .clk(clk), .rst_n(rst_n), .fiber_mode(fiber_mode), .line_lvl(line_lvl),
    .rxd(rxd), .rx_dv(rx_dv), .rx_er(rx_er), .rx_stb(rx_stb), .scr_locked(scr_locked)
  );

  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (rx_stb && ncap < 512) begin
      cap_d[ncap] = rxd;
      cap_e[ncap] = rx_er;
      ncap = ncap + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic logic [4:0] enc(input logic [3:0] n);
    case (n)
      4'h0: return 5'b11110; 4'h1: return 5'b01001; 4'h2: return 5'b10100; 4'h3: return 5'b10101;
      4'h4: return 5'b01010; 4'h5: return 5'b01011; 4'h6: return 5'b01110; 4'h7: return 5'b01111;
      4'h8: return 5'b10010; 4'h9: return 5'b10011; 4'hA: return 5'b10110; 4'hB: return 5'b10111;
      4'hC: return 5'b11010; 4'hD: return 5'b11011; 4'hE: return 5'b11100; default: return 5'b11101;
    endcase
  endfunction

  task automatic send_bit(input logic b);
    logic k, o;
    @(negedge clk);
    if (!fiber_mode) begin
      k = tx_sr[10] ^ tx_sr[8];
      tx_sr = {tx_sr[9:0], k};
      o = b ^ k;
      if (o) mlt_ph = mlt_ph + 2'd1;
      line_lvl = (mlt_ph == 2'd1) ? 2'b01 : (mlt_ph == 2'd3) ? 2'b10 : 2'b00;
    end else begin
      if (b) fnz = ~fnz;
      line_lvl = {1'b0, fnz};
    end
  endtask

  task automatic send_grp(input logic [4:0] g);
    for (int i = 4; i >= 0; i--) send_bit(g[i]);
  endtask

  task automatic send_idle(input int nbits);
    for (int i = 0; i < nbits; i++) send_bit(1'b1);
  endtask

  task automatic run_frame(input int n, input int bad_at, input bit tr_end, input string req);
    logic [3:0] nib;
    ncap = 0;
    nexp = 0;
    send_grp(5'b11000);
    send_grp(5'b10001);
    for (int i = 0; i < n; i++) begin
      if (i == bad_at) begin
        send_grp(5'b00000);
        exp_d[nexp] = 4'h0; exp_e[nexp] = 1'b1;
      end else begin
        nib = 4'($urandom % 16);
        send_grp(enc(nib));
        exp_d[nexp] = nib; exp_e[nexp] = 1'b0;
      end
      nexp++;
    end
    if (tr_end) begin
      send_grp(5'b01101);
      send_grp(5'b00111);
    end else begin
      send_grp(5'b11111);
    end
    send_idle(60);
    #1;
    chk(ncap == nexp, {req, " nibble count"}, ncap, nexp);
    for (int i = 0; i < nexp && i < ncap; i++) begin
      chk(cap_d[i] == exp_d[i], {req, " nibble value"}, cap_d[i], exp_d[i]);
      chk(cap_e[i] == exp_e[i], {req, " error flag R8"}, cap_e[i], exp_e[i]);
    end
    chk(rx_dv == 1'b0, {req, " dv low after end"}, rx_dv, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [3:0] nib;
    int good;
    void'($urandom(32'h1d62));
    repeat (3) @(negedge clk);
    #1;
    chk(rx_dv == 0 && rx_er == 0 && rx_stb == 0, "R11 reset outputs", {rx_dv, rx_er, rx_stb}, 0);
    chk(scr_locked == 0, "R11 reset lock", scr_locked, 0);
    @(negedge clk);
    rst_n = 1'b1;

    send_idle(300);
    #1;
    chk(scr_locked == 1, "R3 lock on idle", scr_locked, 1);

    run_frame(20, -1, 1'b1, "R1 R2 R4 R5 R6 copper T/R frame");
    send_idle(7);
    run_frame(12, 3, 1'b1, "R8 undefined group copper");
    send_idle(3);
    run_frame(9, -1, 1'b0, "R7 idle ends frame");
    run_frame(1, -1, 1'b1, "R4 single nibble frame");

    for (int i = 0; i < 2100; i++) send_bit(1'b0);
    #1;
    chk(scr_locked == 0, "R9 timeout on no idle", scr_locked, 0);
    chk(rx_dv == 0, "R9 dv low when unlocked", rx_dv, 0);
    send_idle(300);
    #1;
    chk(scr_locked == 1, "R3 relock after timeout", scr_locked, 1);

    ncap = 0;
    nexp = 0;
    send_grp(5'b11000);
    send_grp(5'b10001);
    for (int i = 0; i < 450; i++) begin
      nib = 4'($urandom % 16);
      send_grp(enc(nib));
      exp_d[i] = nib;
      nexp++;
    end
    #1;
    chk(scr_locked == 0, "R9 lock lost mid frame", scr_locked, 0);
    chk(rx_dv == 0, "R9 frame aborted", rx_dv, 0);
    chk(ncap > 300 && ncap < 450, "R9 truncated count", ncap, 400);
    good = 1;
    for (int i = 0; i < ncap; i++) if (cap_d[i] != exp_d[i] || cap_e[i]) good = 0;
    chk(good == 1, "R9 truncated prefix matches", good, 1);
    send_grp(5'b01101);
    send_grp(5'b00111);
    send_idle(300);
    #1;
    chk(scr_locked == 1, "R3 relock after abort", scr_locked, 1);
    run_frame(8, -1, 1'b1, "R5 copper frame after relock");

    @(negedge clk);
    fiber_mode = 1'b1;
    #1;
    chk(scr_locked == 1, "R10 fiber lock", scr_locked, 1);
    send_idle(40);
    run_frame(16, -1, 1'b1, "R10 fiber frame");
    run_frame(10, 6, 1'b1, "R10 R8 fiber undefined group");
    run_frame(5, -1, 1'b0, "R10 R7 fiber idle end");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule